// File: doc/BRIEF.md
# Two-Wire Bus Timeout Monitor

This block watches the clock (SCL) and data (SDA) lines of a two-wire serial bus and flags three line conditions that last too long. The first is SCL held low past a programmed limit. The second is both lines sitting high, which shows that the bus is free. The third is SCL high while SDA is held low, which is a stuck data line. A single 16-bit limit sets all three. The SCL-low check compares against the full limit. The two SCL-high checks compare against the limit shifted right by nine bits, so their thresholds are 512 times shorter.

Both line inputs pass through a two-stage synchroniser. Each condition then has its own run-length counter, which advances on the ticks of a prescaler. The prescaler ticks either on every clock or once in every 64 clocks. Software reaches the limit, the control bits and the status flags through a byte-wide register port: a write strobe, an address and write data, plus combinational read data. An interrupt output carries the stuck-SDA flag when its enable bit is set.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset every register reads 0, no flag is set and irq_o is 0.
- R2: Address 0 holds the low byte of the limit and address 1 the high byte. Address 2 is control: bit 0 is the rate select and bit 1 is the stuck-SDA interrupt enable, and its other bits read as 0. Address 3 is status: bit 0 is the low-timeout flag, bit 1 the bus-free flag and bit 2 the stuck-SDA flag. A write updates the register on the next rising edge.
- R3: With rate select 1 the counters advance on every clock. With rate select 0 they advance once every 64 clocks.
- R4: While the limit is 0, none of the three flags can set.
- R5: The low-timeout flag sets once SCL has been low for more than limit ticks. At the fast rate it reads 1 exactly limit+3 rising edges after SCL is driven low (two synchroniser stages, then counting), and still reads 0 one edge earlier.
- R6: If the condition breaks for even one synchronised cycle, its counter restarts from zero.
- R7: A flag sets only once per unbroken interval: after software clears it, it does not set again while the same condition lasts.
- R8: The low-timeout flag and the stuck-SDA flag clear when a 1 is written to their status bit. Writing 0 leaves them unchanged. A set in the same cycle as a clear wins.
- R9: The bus-free flag sets when SCL and SDA have both been high for more than limit>>9 ticks, and at the fast rate it reads 1 after limit>>9 + 3 edges. It ignores writes. It reads 0 three rising edges after either line is driven low.
- R10: The stuck-SDA flag sets when SCL is high and SDA is low for more than limit>>9 ticks, and at the fast rate it reads 1 after limit>>9 + 3 edges.
- R11: irq_o equals the stuck-SDA flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_o | output | 1 | Stuck-SDA interrupt |

## Verification
The bench sweeps small limits at the fast rate and checks each flag one edge before and exactly at its expected set edge. A design that lost a synchroniser stage, or that compared with "at least" instead of "more than", would show up one cycle early there. One trial breaks SCL-low for a single cycle just short of the limit, which catches a counter that holds its count instead of restarting. A clear is timed to land on the same edge as a set, which catches clear-over-set priority. A second clear during a condition that keeps going catches a counter that wraps and sets the flag again. Other checks cover the slow rate, a zero limit, writes to the read-only bus-free flag, and the interrupt mask.

// File: rtl/btm_pkg.sv
package btm_pkg;
    localparam int REG_DW = 8;

    typedef enum logic [1:0] {
        ADDR_LIM_LO = 2'd0,
        ADDR_LIM_HI = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_STAT   = 2'd3
    } reg_addr_e;

    // bit 0 = rate select, bit 1 = stuck-SDA interrupt enable
    typedef struct packed {
        logic stuck_ie;
        logic fast;
    } ctrl_t;

    // bit 0 = low timeout, bit 1 = bus free, bit 2 = stuck SDA
    typedef struct packed {
        logic stuck;
        logic idle;
        logic low;
    } stat_t;
endpackage

// File: rtl/btm_sync.sv
module btm_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];
    logic [W-1:0] st_d [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign st_d[i] = d;
        end else begin : g_rest
            assign st_d[i] = st_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[i] <= '0;
            else        st_q[i] <= st_d[i];
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/btm_prescaler.sv
module btm_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        tick  = fast | (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/btm_run_counter.sv
module btm_run_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] thr,
    output logic         hit
);
    logic [W:0] cnt_q, cnt_d;
    logic [W:0] thr_x;

    always_comb begin
        thr_x = {1'b0, thr};
        hit   = en && tick && (cnt_q == thr_x);
        if (!en)                          cnt_d = '0;
        else if (tick && cnt_q <= thr_x)  cnt_d = cnt_q + 1'b1;
        else                              cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor
    import btm_pkg::*;
#(
    parameter int PRESC_DIV   = 64,
    parameter int HI_SHIFT    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq_o
);
    localparam int LIM_W = 2 * REG_DW;
    localparam int HI_W  = LIM_W - HI_SHIFT;

    typedef struct packed {
        logic [LIM_W-1:0] limit;
        ctrl_t            ctrl;
        stat_t            stat;
    } regs_t;

    regs_t r_q, r_d;

    logic scl_s, sda_s, tick;
    logic limit_on, low_en, idle_en, stuck_en;
    logic low_hit, idle_hit, stuck_hit;
    logic wr_stat;
    logic [HI_W-1:0] hi_thr;

    btm_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
    );

    btm_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .fast(r_q.ctrl.fast), .tick(tick)
    );

    assign limit_on = |r_q.limit;
    assign hi_thr   = r_q.limit[LIM_W-1:HI_SHIFT];
    assign low_en   = limit_on & ~scl_s;
    assign idle_en  = limit_on & scl_s & sda_s;
    assign stuck_en = limit_on & scl_s & ~sda_s;

    btm_run_counter #(.W(LIM_W)) u_low_cnt (
        .clk(clk), .rst_n(rst_n), .en(low_en), .tick(tick),
        .thr(r_q.limit), .hit(low_hit)
    );

    btm_run_counter #(.W(HI_W)) u_idle_cnt (
        .clk(clk), .rst_n(rst_n), .en(idle_en), .tick(tick),
        .thr(hi_thr), .hit(idle_hit)
    );

    btm_run_counter #(.W(HI_W)) u_stuck_cnt (
        .clk(clk), .rst_n(rst_n), .en(stuck_en), .tick(tick),
        .thr(hi_thr), .hit(stuck_hit)
    );

    always_comb begin
        r_d     = r_q;
        wr_stat = reg_wr && (reg_addr == ADDR_STAT);
        if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                ADDR_LIM_LO: r_d.limit[REG_DW-1:0]     = reg_wdata;
                ADDR_LIM_HI: r_d.limit[LIM_W-1:REG_DW] = reg_wdata;
                ADDR_CTRL:   r_d.ctrl                  = ctrl_t'(reg_wdata[1:0]);
                default: ;
            endcase
        end
        // write-one-to-clear, set has priority
        r_d.stat.low   = (r_q.stat.low   & ~(wr_stat & reg_wdata[0])) | low_hit;
        r_d.stat.stuck = (r_q.stat.stuck & ~(wr_stat & reg_wdata[2])) | stuck_hit;
        // self-clearing: holds only while both lines stay high
        r_d.stat.idle  = (r_q.stat.idle | idle_hit) & idle_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            ADDR_LIM_LO: reg_rdata = r_q.limit[REG_DW-1:0];
            ADDR_LIM_HI: reg_rdata = r_q.limit[LIM_W-1:REG_DW];
            ADDR_CTRL:   reg_rdata = {{(REG_DW-2){1'b0}}, r_q.ctrl};
            default:     reg_rdata = {{(REG_DW-3){1'b0}}, r_q.stat};
        endcase
    end

    assign irq_o = r_q.stat.stuck & r_q.ctrl.stuck_ie;
endmodule

// File: rtl/btm_checker.sv
module btm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_s,
    input logic        sda_s,
    input logic        limit_zero,
    input logic        low_flag,
    input logic        idle_flag,
    input logic        stuck_flag,
    input logic        stuck_ie,
    input logic        irq_o,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [7:0]  reg_wdata
);
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !stuck_ie |-> !irq_o); // R11

    AST_ZERO_LIMIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        limit_zero |=> !$rose(low_flag) && !$rose(stuck_flag) && !$rose(idle_flag)); // R4

    AST_LOW_NEEDS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_flag) |-> $past(!scl_s)); // R5

    AST_IDLE_NEEDS_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        idle_flag |-> $past(scl_s && sda_s)); // R9

    AST_STUCK_NEEDS_SDA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck_flag) |-> $past(scl_s && !sda_s)); // R10

    AST_LOW_CLEARS_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_flag) |-> $past(reg_wr && reg_addr == 2'd3 && reg_wdata[0])); // R8
endmodule

bind bus_timeout_monitor btm_checker u_btm_checker (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .limit_zero(r_q.limit == '0), .low_flag(r_q.stat.low),
    .idle_flag(r_q.stat.idle), .stuck_flag(r_q.stat.stuck),
    .stuck_ie(r_q.ctrl.stuck_ie), .irq_o(irq_o), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/bus_timeout_monitor_bench.sv
`timescale 1ns/1ps
module bus_timeout_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_timeout_monitor u_bus_timeout_monitor (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic set_limit(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    logic [7:0] d;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk($sformatf("R1 reg %0d after reset", a), d, 0);
        end
        chk("R1 irq after reset", irq, 0);
        @(negedge clk); rst_n = 1'b1;

        // R4: limit zero, lines low then idle
        scl = 1'b0; sda = 1'b0;
        edges(100); rd(2'd3, d); chk("R4 zero limit, lines low", d, 0);
        @(negedge clk); scl = 1'b1; sda = 1'b1;
        edges(100); rd(2'd3, d); chk("R4 zero limit, lines high", d, 0);

        // R2 readback
        set_limit(16'h3CA5); wr(2'd2, 8'hFF);
        rd(2'd0, d); chk("R2 limit low byte", d, 8'hA5);
        rd(2'd1, d); chk("R2 limit high byte", d, 8'h3C);
        rd(2'd2, d); chk("R2 ctrl unused bits read 0", d, 8'h03);
        wr(2'd2, 8'h01);
        rd(2'd2, d); chk("R2 ctrl readback", d, 8'h01);

        // R5/R3 sweep at fast rate
        for (int lim = 1; lim <= 8; lim++) begin
            set_limit(16'(lim));
            @(negedge clk); scl = 1'b1; sda = 1'b1;
            edges(4); wr(2'd3, 8'h05);
            scl = 1'b0;
            edges(lim + 2); rd(2'd3, d);
            chk($sformatf("R5 R3 low flag one edge early, limit %0d", lim), d[0], 0);
            edges(1); rd(2'd3, d);
            chk($sformatf("R5 R3 low flag at limit+3, limit %0d", lim), d[0], 1);
        end

        // R6 break restarts count
        set_limit(16'd6);
        @(negedge clk); scl = 1'b1; edges(4); wr(2'd3, 8'h05);
        scl = 1'b0;
        edges(5);
        @(negedge clk); scl = 1'b1;
        @(negedge clk); scl = 1'b0;
        edges(8); rd(2'd3, d); chk("R6 no flag after break", d[0], 0);
        edges(1); rd(2'd3, d); chk("R6 flag after fresh interval", d[0], 1);

        // R8 set wins / W1C, R7 sets once
        set_limit(16'd4);
        @(negedge clk); scl = 1'b1; edges(4); wr(2'd3, 8'h05);
        scl = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk); reg_addr = 2'd3; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(posedge clk); #1; reg_wr = 1'b0;
        rd(2'd3, d); chk("R8 set wins over clear", d[0], 1);
        wr(2'd3, 8'h00); rd(2'd3, d); chk("R8 write 0 keeps flag", d[0], 1);
        wr(2'd3, 8'h01); rd(2'd3, d); chk("R8 write 1 clears flag", d[0], 0);
        edges(10); rd(2'd3, d); chk("R7 no re-set in same interval", d[0], 0);

        // R10 and R9 sweeps, R11
        for (int t = 0; t < 4; t++) begin
            set_limit(16'(t * 512 + 5));
            wr(2'd2, 8'h01);
            @(negedge clk); scl = 1'b0; sda = 1'b1;
            edges(4); wr(2'd3, 8'h05);
            scl = 1'b1; sda = 1'b0;
            edges(t + 2); rd(2'd3, d);
            chk($sformatf("R10 stuck flag early, thr %0d", t), d[2], 0);
            edges(1); rd(2'd3, d);
            chk($sformatf("R10 stuck flag at thr+3, thr %0d", t), d[2], 1);
            chk($sformatf("R11 irq masked, thr %0d", t), irq, 0);
            wr(2'd2, 8'h03); edges(1);
            chk($sformatf("R11 irq enabled, thr %0d", t), irq, 1);
            wr(2'd3, 8'h04); edges(1);
            chk($sformatf("R11 irq after clear, thr %0d", t), irq, 0);

            @(negedge clk); scl = 1'b0; sda = 1'b1;
            edges(4);
            @(negedge clk); scl = 1'b1; sda = 1'b1;
            edges(t + 2); rd(2'd3, d);
            chk($sformatf("R9 idle flag early, thr %0d", t), d[1], 0);
            edges(1); rd(2'd3, d);
            chk($sformatf("R9 idle flag at thr+3, thr %0d", t), d[1], 1);
            wr(2'd3, 8'h02); rd(2'd3, d);
            chk($sformatf("R9 idle flag ignores write, thr %0d", t), d[1], 1);
            sda = 1'b0;
            edges(2); rd(2'd3, d);
            chk($sformatf("R9 idle held 2 edges, thr %0d", t), d[1], 1);
            edges(1); rd(2'd3, d);
            chk($sformatf("R9 idle clears at 3 edges, thr %0d", t), d[1], 0);
        end

        // R3 slow rate
        wr(2'd2, 8'h00); set_limit(16'd2);
        @(negedge clk); scl = 1'b1; sda = 1'b1; edges(4); wr(2'd3, 8'h05);
        scl = 1'b0;
        edges(128); rd(2'd3, d); chk("R3 slow rate not set at 128", d[0], 0);
        edges(68); rd(2'd3, d); chk("R3 slow rate set by 196", d[0], 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule